// File: doc/BRIEF.md
# Output Stop and Power-Down Sequencer

This block decides, for each of four differential clock output pairs, whether the pair toggles or is parked, and what each leg does while parked. It runs on a digital stand-in for the complement output clock, so one clock period of the block is one output period. Its inputs are a power-down pin, a stop pin, one enable pin per pair, a polarity strap, and static configuration bits: power-down park style, stop park style, power-down pin level, per-pair enable, and a free-run or stoppable choice for the pairs that have one.

Every pin request must be seen at the same level on two consecutive rising edges before the block acts on it. The pair changes state on the edge after that, so a park or an unpark never cuts a clock period short. A central state machine has five states. RUN is normal operation. STOPPED is entered from RUN when the stop request is accepted. RESTART is entered from STOPPED when the stop release is accepted, and it counts `RESUME_CYC` cycles before it returns to RUN. PDOWN is entered from any state when the power-down request is accepted. WAKE is entered from PDOWN when the power-down release is accepted, and it counts the same number of cycles. When WAKE finishes it goes to STOPPED if a stop is still held, or to RUN if not. Reset places the machine in WAKE. An accepted stop request sends RESTART back to STOPPED. Each pair has an output register that is loaded from the machine's next state and from its own debounced enable, so a stop park and an enable park land on the same edge.

Top module: `clk_stop_seq`

## Requirements
- R1: During reset and on the first edge after it, every pair has `pair_run`=0 and both legs at code 0 (tri-state). After startup, with all enables active, every pair runs within ten cycles.
- R2: A power-down request takes effect only when it is seen active on two consecutive edges. If the pin is applied before edge k, the pairs still run after edge k+1 and are parked after edge k+2. A request that lasts one period is ignored.
- R3: In power-down with the power-down park bit at 0, the true leg has code 2 (high, double drive) and the complement leg has code 0. With the bit at 1, both legs have code 0.
- R4: A stop request is filtered in the same two-edge way and parks stoppable pairs after edge k+2. With the stop park bit at 0, the true leg has code 1 (high, normal drive) and the complement leg has code 0. With the bit at 1, both legs have code 0. A stop pulse that lasts one period is ignored.
- R5: Pairs 0 and 3 each have a stoppable bit: 0 means free-running and 1 means stoppable. A free-running pair keeps running through a stop. Pairs 1 and 2 are always stoppable and do not depend on that bit.
- R6: After a stop or power-down release is accepted, the machine stays exactly `RESUME_CYC` (3) cycles in RESTART or WAKE. All parked pairs restart on one shared edge. For a release applied before edge j, the pairs are still parked after edge j+4 and run after edge j+5.
- R7: A pair runs only if its configuration enable bit is 1 and its enable pin is at its active level. A disabled pair has both legs at code 0, and this applies during power-down too. The change takes effect with the same two-edge filter and park edge as the stop path.
- R8: When the strap is latched at 1, the enable pins are active-low and the stop and power-down pins are active-high. When it is latched at 0, the enable pins are active-high and the stop and power-down pins are active-low.
- R9: The power-down level bit flips the power-down pin level on top of the strap (strap XOR bit gives the active level).
- R10: The strap is captured on the first edge after reset release and is held until the next reset. Later changes on the strap pin have no effect.
- R11: Power-down takes priority over stop. If power-down is released while stop is still held, the pairs pass through WAKE and then park as stopped pairs.
- R12: A running pair shows code 3 (toggle) on both legs, and a parked pair never shows code 3. A complement leg is never driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stand-in for the complement output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_pin | input | 1 | Polarity strap, latched after reset |
| pd_pin | input | 1 | Power-down request pin |
| stop_pin | input | 1 | Stop request pin |
| oe_pin | input | NUM_OUT | Per-pair enable pins |
| cfg_pd_tristate | input | 1 | Power-down park style: 0 driven high, 1 tri-state |
| cfg_stop_tristate | input | 1 | Stop park style: 0 driven high, 1 tri-state |
| cfg_pd_hi | input | 1 | Power-down level select, XOR with strap |
| cfg_out_en | input | NUM_OUT | Per-pair configuration enable |
| cfg_stoppable | input | NUM_OUT | Stoppable (1) or free-running (0), used on selectable pairs |
| pair_run | output | NUM_OUT | Pair is toggling |
| leg_true | output | 2*NUM_OUT | True-leg drive code per pair (pair i at bits 2i+1:2i) |
| leg_comp | output | 2*NUM_OUT | Complement-leg drive code per pair |

## Verification
The hardest case to reach is a power-down release that arrives while a stop is still being held. The machine has to pass through WAKE and then enter STOPPED, with free-running and stoppable pairs ending in different states. The bench reaches this case by stopping first, applying power-down on top of the stop, and releasing only the power-down. It then checks the exact edge at which each pair changes. Single-period pulses on the stop and power-down pins are driven on falling edges, so that exactly one rising edge sees them, which exercises the two-edge filter. A second reset with the strap high covers the inverted pin senses.

// File: rtl/cso_pkg.sv
package cso_pkg;

    // Per-leg drive code
    typedef enum logic [1:0] {
        LEG_Z   = 2'd0,   // not driven
        LEG_HI  = 2'd1,   // driven high, normal current
        LEG_HI2 = 2'd2,   // driven high, double current
        LEG_TOG = 2'd3    // toggling with the clock
    } leg_code_t;

    typedef enum logic [2:0] {
        SQ_RUN     = 3'd0,
        SQ_STOPPED = 3'd1,
        SQ_RESTART = 3'd2,
        SQ_PDOWN   = 3'd3,
        SQ_WAKE    = 3'd4
    } seq_state_t;

endpackage

// File: rtl/cso_debounce.sv
module cso_debounce #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] raw,
    output logic [W-1:0] deb
);

    logic [W-1:0] smp_q;
    logic [W-1:0] deb_q;

    // A bit follows the input only when this edge and the previous one agree
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                smp_q[b] <= 1'b0;
                deb_q[b] <= 1'b0;
            end else if (en) begin
                smp_q[b] <= raw[b];
                if (raw[b] == smp_q[b]) begin
                    deb_q[b] <= raw[b];
                end
            end
        end
    end

    assign deb = deb_q;

endmodule

// File: rtl/cso_seq_fsm.sv
module cso_seq_fsm
    import cso_pkg::*;
#(
    parameter int RESUME_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_req,
    input  logic       stop_req,
    output seq_state_t state_q,
    output logic       hold_pd,
    output logic       hold_stop
);

    localparam int CNT_W = (RESUME_CYC > 1) ? $clog2(RESUME_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RESUME_CYC - 1);

    seq_state_t       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_WAKE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SQ_RUN: begin
                if (pd_req) begin
                    state_d = SQ_PDOWN;
                end else if (stop_req) begin
                    state_d = SQ_STOPPED;
                end
            end
            SQ_STOPPED: begin
                if (pd_req) begin
                    state_d = SQ_PDOWN;
                end else if (!stop_req) begin
                    state_d = SQ_RESTART;
                    cnt_d   = '0;
                end
            end
            SQ_RESTART: begin
                if (pd_req) begin
                    state_d = SQ_PDOWN;
                end else if (stop_req) begin
                    state_d = SQ_STOPPED;
                end else if (cnt_q == LAST) begin
                    state_d = SQ_RUN;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            SQ_PDOWN: begin
                if (!pd_req) begin
                    state_d = SQ_WAKE;
                    cnt_d   = '0;
                end
            end
            SQ_WAKE: begin
                if (pd_req) begin
                    state_d = SQ_PDOWN;
                end else if (cnt_q == LAST) begin
                    state_d = stop_req ? SQ_STOPPED : SQ_RUN;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = SQ_WAKE;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs: park view of the next state so the lanes load it on the same edge
    always_comb begin
        hold_pd   = 1'b0;
        hold_stop = 1'b0;
        unique case (state_d)
            SQ_PDOWN, SQ_WAKE:      hold_pd   = 1'b1;
            SQ_STOPPED, SQ_RESTART: hold_stop = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/cso_lane.sv
module cso_lane
    import cso_pkg::*;
#(
    parameter bit HAS_FREE_SEL = 1'b0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_ok,
    input  logic      hold_pd,
    input  logic      hold_stop,
    input  logic      cfg_pd_tristate,
    input  logic      cfg_stop_tristate,
    input  logic      cfg_stoppable,
    output logic      run,
    output leg_code_t leg_t,
    output leg_code_t leg_c
);

    logic      stoppable;
    logic      run_d;
    leg_code_t leg_t_d;
    leg_code_t leg_c_d;

    if (HAS_FREE_SEL) begin : g_sel
        assign stoppable = cfg_stoppable;
    end else begin : g_fixed
        logic unused_sel;
        assign unused_sel = cfg_stoppable;
        assign stoppable  = 1'b1;
    end

    always_comb begin
        run_d   = 1'b0;
        leg_t_d = LEG_Z;
        leg_c_d = LEG_Z;
        if (!en_ok) begin
            leg_t_d = LEG_Z;
        end else if (hold_pd) begin
            leg_t_d = cfg_pd_tristate ? LEG_Z : LEG_HI2;
        end else if (hold_stop && stoppable) begin
            leg_t_d = cfg_stop_tristate ? LEG_Z : LEG_HI;
        end else begin
            run_d   = 1'b1;
            leg_t_d = LEG_TOG;
            leg_c_d = LEG_TOG;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run   <= 1'b0;
            leg_t <= LEG_Z;
            leg_c <= LEG_Z;
        end else begin
            run   <= run_d;
            leg_t <= leg_t_d;
            leg_c <= leg_c_d;
        end
    end

endmodule

// File: rtl/clk_stop_seq.sv
module clk_stop_seq
    import cso_pkg::*;
#(
    parameter int               NUM_OUT       = 4,
    parameter int               RESUME_CYC    = 3,
    parameter logic [NUM_OUT-1:0] FREE_SEL_MASK = 4'b1001
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   strap_pin,
    input  logic                   pd_pin,
    input  logic                   stop_pin,
    input  logic [NUM_OUT-1:0]     oe_pin,
    input  logic                   cfg_pd_tristate,
    input  logic                   cfg_stop_tristate,
    input  logic                   cfg_pd_hi,
    input  logic [NUM_OUT-1:0]     cfg_out_en,
    input  logic [NUM_OUT-1:0]     cfg_stoppable,
    output logic [NUM_OUT-1:0]     pair_run,
    output logic [2*NUM_OUT-1:0]   leg_true,
    output logic [2*NUM_OUT-1:0]   leg_comp
);

    localparam int DB_W = NUM_OUT + 2;

    logic               strap_q;
    logic               valid_q;
    logic               pd_act;
    logic               stop_act;
    logic [NUM_OUT-1:0] en_raw;
    logic [DB_W-1:0]    deb;
    logic               pd_deb;
    logic               stop_deb;
    logic [NUM_OUT-1:0] en_deb;
    seq_state_t         seq_state;
    logic               hold_pd;
    logic               hold_stop;

    // Strap capture: first edge after reset, held until next reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strap_q <= 1'b0;
            valid_q <= 1'b0;
        end else if (!valid_q) begin
            strap_q <= strap_pin;
            valid_q <= 1'b1;
        end
    end

    // Pin senses normalised to active-high
    assign pd_act   = (pd_pin == (strap_q ^ cfg_pd_hi));
    assign stop_act = (stop_pin == strap_q);
    assign en_raw   = cfg_out_en & (oe_pin ^ {NUM_OUT{strap_q}});

    cso_debounce #(.W(DB_W)) u_deb (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (valid_q),
        .raw   ({en_raw, stop_act, pd_act}),
        .deb   (deb)
    );

    assign pd_deb   = deb[0];
    assign stop_deb = deb[1];
    assign en_deb   = deb[DB_W-1:2];

    cso_seq_fsm #(.RESUME_CYC(RESUME_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd_req    (pd_deb),
        .stop_req  (stop_deb),
        .state_q   (seq_state),
        .hold_pd   (hold_pd),
        .hold_stop (hold_stop)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
        leg_code_t lt;
        leg_code_t lc;
        cso_lane #(.HAS_FREE_SEL(FREE_SEL_MASK[i])) u_lane (
            .clk               (clk),
            .rst_n             (rst_n),
            .en_ok             (en_deb[i]),
            .hold_pd           (hold_pd),
            .hold_stop         (hold_stop),
            .cfg_pd_tristate   (cfg_pd_tristate),
            .cfg_stop_tristate (cfg_stop_tristate),
            .cfg_stoppable     (cfg_stoppable[i]),
            .run               (pair_run[i]),
            .leg_t             (lt),
            .leg_c             (lc)
        );
        assign leg_true[2*i +: 2] = lt;
        assign leg_comp[2*i +: 2] = lc;
    end

endmodule

// File: rtl/cso_checker.sv
module cso_checker
    import cso_pkg::*;
#(
    parameter int NUM_OUT    = 4,
    parameter int RESUME_CYC = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input seq_state_t           seq_state,
    input logic                 pd_act,
    input logic                 stop_act,
    input logic                 strap_q,
    input logic                 valid_q,
    input logic [NUM_OUT-1:0]   pair_run,
    input logic [2*NUM_OUT-1:0] leg_true,
    input logic [2*NUM_OUT-1:0] leg_comp
);

    localparam int RW = $clog2(RESUME_CYC + 2);

    logic [RW-1:0] rcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcnt <= '0;
        end else if (seq_state == SQ_RESTART) begin
            rcnt <= rcnt + 1'b1;
        end else begin
            rcnt <= '0;
        end
    end

    p_pd_two_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_state == SQ_PDOWN) |-> ($past(pd_act, 1) && $past(pd_act, 2)));

    p_stop_two_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(seq_state == SQ_STOPPED) && $past(seq_state) == SQ_RUN)
            |-> ($past(stop_act, 1) && $past(stop_act, 2)));

    p_restart_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SQ_RUN && $past(seq_state) == SQ_RESTART)
            |-> (rcnt == RW'(RESUME_CYC)));

    p_restart_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SQ_RESTART) |-> (rcnt < RW'(RESUME_CYC)));

    p_strap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> $stable(strap_q));

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_pair
        p_run_toggles_r12: assert property (@(posedge clk) disable iff (!rst_n)
            pair_run[i] |-> (leg_true[2*i +: 2] == 2'd3 && leg_comp[2*i +: 2] == 2'd3));
        p_park_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
            !pair_run[i] |-> (leg_true[2*i +: 2] != 2'd3 && leg_comp[2*i +: 2] != 2'd3));
        p_comp_not_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (leg_comp[2*i +: 2] != 2'd1 && leg_comp[2*i +: 2] != 2'd2));
    end

endmodule

bind clk_stop_seq cso_checker #(
    .NUM_OUT    (NUM_OUT),
    .RESUME_CYC (RESUME_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .seq_state (seq_state),
    .pd_act    (pd_act),
    .stop_act  (stop_act),
    .strap_q   (strap_q),
    .valid_q   (valid_q),
    .pair_run  (pair_run),
    .leg_true  (leg_true),
    .leg_comp  (leg_comp)
);

// File: tb/tb_clk_stop_seq.sv
module tb_clk_stop_seq;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       strap_pin;
    logic       pd_pin;
    logic       stop_pin;
    logic [3:0] oe_pin;
    logic       cfg_pd_tristate;
    logic       cfg_stop_tristate;
    logic       cfg_pd_hi;
    logic [3:0] cfg_out_en;
    logic [3:0] cfg_stoppable;
    logic [3:0] pair_run;
    logic [7:0] leg_true;
    logic [7:0] leg_comp;

    clk_stop_seq dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .strap_pin         (strap_pin),
        .pd_pin            (pd_pin),
        .stop_pin          (stop_pin),
        .oe_pin            (oe_pin),
        .cfg_pd_tristate   (cfg_pd_tristate),
        .cfg_stop_tristate (cfg_stop_tristate),
        .cfg_pd_hi         (cfg_pd_hi),
        .cfg_out_en        (cfg_out_en),
        .cfg_stoppable     (cfg_stoppable),
        .pair_run          (pair_run),
        .leg_true          (leg_true),
        .leg_comp          (leg_comp)
    );

    always #4 clk = ~clk;

    // Codes: 0 tri-state, 1 high, 2 high double drive, 3 toggle
    localparam logic [7:0] ALL_TOG = 8'hFF;
    localparam logic [7:0] ALL_HI2 = 8'hAA;
    localparam logic [7:0] ALL_HI  = 8'h55;

    typedef struct {
        int         cyc;
        logic [3:0] run;
        logic [7:0] t;
        logic [7:0] c;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(input int dly, input logic [3:0] r, input logic [7:0] t,
                        input logic [7:0] c, input string tag);
        exp_q.push_back('{cyc + dly, r, t, c, tag});
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops items that are due and compares them with the ports
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
            exp_t it;
            it = exp_q.pop_front();
            n_chk++;
            if (it.cyc != cyc || pair_run !== it.run || leg_true !== it.t || leg_comp !== it.c) begin
                n_fail++;
                $display("FAIL %s: run=%h true=%h comp=%h expected run=%h true=%h comp=%h",
                         it.tag, pair_run, leg_true, leg_comp, it.run, it.t, it.c);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not end, actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; strap_pin = 1'b0; pd_pin = 1'b1; stop_pin = 1'b1;
        oe_pin = 4'hF; cfg_pd_tristate = 1'b0; cfg_stop_tristate = 1'b0;
        cfg_pd_hi = 1'b0; cfg_out_en = 4'hF; cfg_stoppable = 4'hF;
        tick(1);
        push(1, 4'h0, 8'h00, 8'h00, "R1 parked in reset");
        tick(3);
        rst_n = 1'b1;
        push(1, 4'h0, 8'h00, 8'h00, "R1 parked on first edge");
        push(10, 4'hF, ALL_TOG, ALL_TOG, "R1 R12 running after startup");
        tick(12);

        // R2: one-period power-down pulse is ignored
        pd_pin = 1'b0;
        tick(1);
        pd_pin = 1'b1;
        push(2, 4'hF, ALL_TOG, ALL_TOG, "R2 pd glitch ignored");
        push(4, 4'hF, ALL_TOG, ALL_TOG, "R2 pd glitch ignored later");
        tick(6);

        // R2/R3: held power-down, driven park
        pd_pin = 1'b0;
        push(2, 4'hF, ALL_TOG, ALL_TOG, "R2 still running after second edge");
        push(3, 4'h0, ALL_HI2, 8'h00, "R3 pd park driven");
        tick(4);
        pd_pin = 1'b1;
        push(5, 4'h0, ALL_HI2, 8'h00, "R6 still parked in wake");
        push(6, 4'hF, ALL_TOG, ALL_TOG, "R6 resume after pd");
        tick(8);

        // R3: tri-state power-down park
        cfg_pd_tristate = 1'b1;
        pd_pin = 1'b0;
        push(3, 4'h0, 8'h00, 8'h00, "R3 pd park tristate");
        tick(4);
        pd_pin = 1'b1;
        push(6, 4'hF, ALL_TOG, ALL_TOG, "R6 resume after tristate pd");
        tick(8);
        cfg_pd_tristate = 1'b0;

        // R4: stop, driven park
        stop_pin = 1'b0;
        push(2, 4'hF, ALL_TOG, ALL_TOG, "R4 still running after second edge");
        push(3, 4'h0, ALL_HI, 8'h00, "R4 stop park driven");
        tick(4);
        stop_pin = 1'b1;
        push(5, 4'h0, ALL_HI, 8'h00, "R6 still parked in restart");
        push(6, 4'hF, ALL_TOG, ALL_TOG, "R6 all restart together");
        tick(8);

        // R4: one-period stop pulse
        stop_pin = 1'b0;
        tick(1);
        stop_pin = 1'b1;
        push(3, 4'hF, ALL_TOG, ALL_TOG, "R4 stop glitch ignored");
        tick(5);

        // R5: free-running pairs 0 and 3, tri-state stop park on 1 and 2
        cfg_stop_tristate = 1'b1;
        cfg_stoppable = 4'h0;
        stop_pin = 1'b0;
        push(3, 4'b1001, 8'hC3, 8'hC3, "R5 free pairs keep running");
        tick(4);

        // R11: power-down over stop, then release power-down only
        pd_pin = 1'b0;
        push(3, 4'h0, ALL_HI2, 8'h00, "R11 pd overrides stop");
        tick(4);
        pd_pin = 1'b1;
        push(5, 4'h0, ALL_HI2, 8'h00, "R11 wake holds pd park");
        push(6, 4'b1001, 8'hC3, 8'hC3, "R11 back to stop park");
        tick(8);
        stop_pin = 1'b1;
        push(6, 4'hF, ALL_TOG, ALL_TOG, "R6 resume after stop");
        tick(8);
        cfg_stoppable = 4'hF;
        cfg_stop_tristate = 1'b0;

        // R7: pin and register enables
        oe_pin = 4'b1011;
        push(2, 4'hF, ALL_TOG, ALL_TOG, "R7 disable not yet taken");
        push(3, 4'b1011, 8'hCF, 8'hCF, "R7 pin disable parks tristate");
        tick(4);
        oe_pin = 4'hF;
        cfg_out_en = 4'b1101;
        push(3, 4'b1101, 8'hF3, 8'hF3, "R7 register disable parks tristate");
        tick(4);
        cfg_out_en = 4'hF;
        push(3, 4'hF, ALL_TOG, ALL_TOG, "R7 re-enable");
        tick(4);

        // R9: power-down level bit
        cfg_pd_hi = 1'b1;
        pd_pin = 1'b0;
        push(3, 4'hF, ALL_TOG, ALL_TOG, "R9 low level inactive");
        tick(4);
        pd_pin = 1'b1;
        push(3, 4'h0, ALL_HI2, 8'h00, "R9 high level powers down");
        tick(4);
        pd_pin = 1'b0;
        push(6, 4'hF, ALL_TOG, ALL_TOG, "R9 release");
        tick(8);
        cfg_pd_hi = 1'b0;
        pd_pin = 1'b1;
        tick(4);

        // R10: strap change after capture has no effect
        strap_pin = 1'b1;
        push(3, 4'hF, ALL_TOG, ALL_TOG, "R10 strap change ignored");
        push(6, 4'hF, ALL_TOG, ALL_TOG, "R10 strap change still ignored");
        tick(7);

        // R8: restart with strap high, inverted senses
        rst_n = 1'b0;
        pd_pin = 1'b0;
        stop_pin = 1'b0;
        oe_pin = 4'h0;
        tick(3);
        rst_n = 1'b1;
        push(10, 4'hF, ALL_TOG, ALL_TOG, "R8 inverted pins run");
        tick(12);
        stop_pin = 1'b1;
        push(3, 4'h0, ALL_HI, 8'h00, "R8 stop active high");
        tick(4);
        stop_pin = 1'b0;
        push(6, 4'hF, ALL_TOG, ALL_TOG, "R8 stop release");
        tick(8);
        oe_pin = 4'b0001;
        push(3, 4'b1110, 8'hFC, 8'hFC, "R8 enable pin active low");
        tick(4);
        pd_pin = 1'b1;
        push(3, 4'h0, 8'hA8, 8'h00, "R8 R7 pd active high, disabled pair stays tristate");
        tick(5);

        n_chk++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard drain: pending=%0d expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule